// File: doc/BRIEF.md
# Programmable Interrupt Controller Unit

This block gathers up to 32 interrupt request lines and turns them into two outputs: a normal-priority request and an urgent-priority request. Each line can be set to respond to a level or to an edge, and to the high or the low sense of the signal. Every detected event sets a bit in a pending register. Software clears a pending bit by writing a one to it.

The pending bits are gated by an enable register. A routing register then sends each enabled pending bit to either the urgent output or the normal output. A read-only view returns only the pending bits that are also enabled. Each output can drive one input of a parent unit of the same kind, which allows several units to be chained. Software reaches all registers through a single-cycle bus: a write takes effect at the clock edge, and a read returns its value combinationally from the address.

Top module: `intc_unit`

## Requirements
- R1: Source n (the line `irq_in[n]`) is held in register bit NSRC-1-n in every register, so source 0 is the most significant bit. Register addresses: 0 pending, 1 enable, 2 urgent routing, 3 polarity, 4 trigger, 5 masked pending (read-only). Any other address reads as zero.
- R2: Writing the pending register clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones clears every pending bit that has no new event.
- R3: A source with trigger bit 0 is level-sensitive. While its synchronized input matches its polarity, its pending bit is set on every clock, so a clear does not remove it while the input stays active.
- R4: A source with trigger bit 1 is edge-sensitive. One edge in the chosen direction sets its pending bit, and the bit stays set after the input returns to idle until a write of 1 clears it.
- R5: Polarity bit 1 selects active-high or a rising edge. Polarity bit 0 selects active-low or a falling edge.
- R6: A source whose enable bit is 0 still latches its pending bit but never raises either output.
- R7: The normal output is the registered OR of the masked pending bits whose routing bit is 0. The urgent output is the registered OR of those whose routing bit is 1.
- R8: Reset clears every register and both outputs.
- R9: If a clear and a new event hit the same pending bit in one cycle, the bit stays set.
- R10: The masked pending register reads as pending AND enable, and writes to it have no effect.
- R11: Each input passes two synchronizer flops, so a pending bit sets on the third rising edge after the input changes. An output follows its masked pending bits one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Raw interrupt request lines, index = source number |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Register read data (combinational) |
| irq_nc | output | 1 | Normal-priority interrupt request |
| irq_crit | output | 1 | Urgent-priority interrupt request |

## Verification
The bench builds the unit with the default NSRC of 32 and AW of 3. This covers the full source-to-bit reversal and all six register addresses, including the read-only view and writes to it. A behavioural model tracks the synchronizer delay, the pending bits, the writes and both outputs, and it compares the outputs and the addressed read data on every clock. The directed sequences cover a clear while a level source is still active, edge stickiness in both directions, disabled sources that latch, routing to the urgent output, and a clear that lands in the same cycle as a new edge.

// File: rtl/intc_unit.sv
module intc_unit #(
  parameter int NSRC = 32,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_nc,
  output logic            irq_crit
);
  localparam logic [AW-1:0] A_PEND = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_URG  = AW'(2);
  localparam logic [AW-1:0] A_POL  = AW'(3);
  localparam logic [AW-1:0] A_TRG  = AW'(4);
  localparam logic [AW-1:0] A_MSK  = AW'(5);

  logic [NSRC-1:0] src_r, sync1, sync2, prev;
  logic [NSRC-1:0] stat, enab, crit, pol, trig;
  logic [NSRC-1:0] clr, hit_edge, hit_lvl, mstat;

  for (genvar n = 0; n < NSRC; n++) begin : g_rev
    assign src_r[NSRC-1-n] = irq_in[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= src_r;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign clr      = (reg_we && reg_addr == A_PEND) ? reg_wdata : '0;
  assign hit_edge = trig & ((pol & sync2 & ~prev) | (~pol & ~sync2 & prev));
  assign hit_lvl  = ~trig & ~(sync2 ^ pol);
  assign mstat    = stat & enab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      enab <= '0;
      crit <= '0;
      pol  <= '0;
      trig <= '0;
    end else begin
      stat <= hit_edge | hit_lvl | (stat & ~clr);
      if (reg_we && reg_addr == A_EN)  enab <= reg_wdata;
      if (reg_we && reg_addr == A_URG) crit <= reg_wdata;
      if (reg_we && reg_addr == A_POL) pol  <= reg_wdata;
      if (reg_we && reg_addr == A_TRG) trig <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_nc   <= 1'b0;
      irq_crit <= 1'b0;
    end else begin
      irq_nc   <= |(mstat & ~crit);
      irq_crit <= |(mstat & crit);
    end
  end

  always_comb begin
    case (reg_addr)
      A_PEND:  reg_rdata = stat;
      A_EN:    reg_rdata = enab;
      A_URG:   reg_rdata = crit;
      A_POL:   reg_rdata = pol;
      A_TRG:   reg_rdata = trig;
      A_MSK:   reg_rdata = mstat;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module intc_unit_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [AW-1:0]   reg_addr,
  input logic [NSRC-1:0] reg_wdata,
  input logic [NSRC-1:0] stat,
  input logic [NSRC-1:0] enab,
  input logic [NSRC-1:0] crit,
  input logic [NSRC-1:0] pol,
  input logic [NSRC-1:0] trig,
  input logic [NSRC-1:0] sync2,
  input logic            irq_nc,
  input logic            irq_crit
);
  logic [NSRC-1:0] wr_ones;
  assign wr_ones = (reg_we && reg_addr == '0) ? reg_wdata : '0;

  p_nc_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nc |-> $past(|(stat & enab & ~crit)));

  p_crit_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit |-> $past(|(stat & enab & crit)));

  p_quiet_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enab == '0) |=> (!irq_nc && !irq_crit));

  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~trig & ~(sync2 ^ pol)) & ~stat) == '0));

  p_edge_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat & trig & ~wr_ones) & ~stat) == '0));
endmodule

bind intc_unit intc_unit_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .stat(stat), .enab(enab), .crit(crit),
  .pol(pol), .trig(trig), .sync2(sync2), .irq_nc(irq_nc),
  .irq_crit(irq_crit)
);

// File: tb/intc_unit_test.sv
module intc_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_nc, irq_crit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  intc_unit uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_nc(irq_nc), .irq_crit(irq_crit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] h1, h2, h3;
  logic [31:0] m_stat, m_en, m_crit, m_pol, m_trig, ns, clrv;
  logic        m_nc, m_cr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0;
      m_stat = '0; m_en = '0; m_crit = '0; m_pol = '0; m_trig = '0;
      m_nc = 0; m_cr = 0;
    end else begin
      clrv = (reg_we && reg_addr == 3'd0) ? reg_wdata : '0;
      for (int b = 0; b < 32; b++) begin
        bit x, y, act;
        x = h2[31-b];
        y = h3[31-b];
        if (m_trig[b]) act = m_pol[b] ? (x && !y) : (!x && y);
        else           act = (x == m_pol[b]);
        ns[b] = act || (m_stat[b] && !clrv[b]);
      end
      m_nc = |(m_stat & m_en & ~m_crit);
      m_cr = |(m_stat & m_en & m_crit);
      if (reg_we) begin
        case (reg_addr)
          3'd1: m_en = reg_wdata;
          3'd2: m_crit = reg_wdata;
          3'd3: m_pol = reg_wdata;
          3'd4: m_trig = reg_wdata;
          default: ;
        endcase
      end
      m_stat = ns;
      h3 = h2; h2 = h1; h1 = irq_in;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_stat;
      3'd1: return m_en;
      3'd2: return m_crit;
      3'd3: return m_pol;
      3'd4: return m_trig;
      3'd5: return m_stat & m_en;
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(irq_nc === m_nc, "R7 R11 normal output vs model", {31'd0, irq_nc}, {31'd0, m_nc});
    check(irq_crit === m_cr, "R7 R11 urgent output vs model", {31'd0, irq_crit}, {31'd0, m_cr});
    check(reg_rdata === m_read(reg_addr), "R1 R10 read data vs model", reg_rdata, m_read(reg_addr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string what);
    reg_addr = a;
    #1;
    check(reg_rdata === exp, what, reg_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R8 register zero in reset");
    check(!irq_nc && !irq_crit, "R8 outputs low in reset", {30'd0, irq_nc, irq_crit}, 32'h0);
    rst_n = 1;
    ticks(2);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd0, 32'hFFFF_FFFF);
    tick();
    rd(3'd0, 32'h0, "R2 write-ones clears all");
    rd(3'd7, 32'h0, "R1 unmapped address reads zero");

    // R1: source 0 at the top bit, level active-high
    wr(3'd1, 32'h8000_0000);
    irq_in[0] = 1;
    ticks(4);
    rd(3'd0, 32'h8000_0000, "R1 source 0 maps to bit 31");
    check(irq_nc === 1'b1, "R7 normal output raised", {31'd0, irq_nc}, 32'h1);

    // R3: clear while level still active
    wr(3'd0, 32'h8000_0000);
    ticks(2);
    rd(3'd0, 32'h8000_0000, "R3 level source re-asserts after clear");
    irq_in[0] = 0;
    ticks(3);
    wr(3'd0, 32'h8000_0000);
    ticks(2);
    rd(3'd0, 32'h0, "R2 clear after input idle");

    // R4 R5: edge sources 5 (rising) and 6 (falling)
    wr(3'd4, 32'h0600_0000);
    wr(3'd3, ~32'h0200_0000);
    irq_in[6] = 1;
    ticks(4);
    wr(3'd0, 32'hFFFF_FFFF);
    ticks(2);
    rd(3'd0, 32'h0, "R2 clean start for edge tests");
    irq_in[5] = 1;
    tick();
    irq_in[5] = 0;
    ticks(5);
    rd(3'd0, 32'h0400_0000, "R4 rising edge stays latched after idle");
    irq_in[6] = 0;
    ticks(4);
    rd(3'd0, 32'h0600_0000, "R5 falling edge latched on source 6");

    // R6: sources 5 and 6 disabled
    check(!irq_nc && !irq_crit, "R6 disabled pending raises no output", {30'd0, irq_nc, irq_crit}, 32'h0);
    rd(3'd5, 32'h0, "R6 masked view empty when disabled");

    // R7 R10: enable source 5 and route it to urgent
    wr(3'd2, 32'h0400_0000);
    wr(3'd1, 32'h8400_0000);
    ticks(2);
    check(irq_crit === 1'b1 && irq_nc === 1'b0, "R7 routed to urgent only", {30'd0, irq_nc, irq_crit}, 32'h1);
    rd(3'd5, 32'h0400_0000, "R10 masked view is pending and enable");
    wr(3'd5, 32'hFFFF_FFFF);
    tick();
    rd(3'd0, 32'h0600_0000, "R10 write to masked view leaves pending");
    rd(3'd5, 32'h0400_0000, "R10 masked view unchanged by write");

    // R9: clear and new edge in the same cycle
    wr(3'd0, 32'hFFFF_FFFF);
    ticks(2);
    rd(3'd0, 32'h0, "R2 pending cleared before collision");
    irq_in[5] = 1;
    tick();
    tick();
    wr(3'd0, 32'h0400_0000);
    tick();
    rd(3'd0, 32'h0400_0000, "R9 new edge wins over clear");
    wr(3'd0, 32'h0400_0000);
    ticks(2);
    rd(3'd0, 32'h0, "R4 held edge input gives no new event");
    irq_in[5] = 0;
    ticks(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule